// File: doc/BRIEF.md
# Deferred Strap Configuration Latch

This block holds the soft strapping options of a 10/100 Ethernet physical-layer port. After power-on the host writes the options through a simple register port. The values it writes are only staged at first, and nothing downstream sees them yet. The host then sets a completion flag in a separate control register. That write raises an internal one-cycle commit pulse, and the pulse copies every staged option into shadow registers at once. The shadow registers drive the rest of the chip.

The shadow values are decoded into five outputs:
- a polarity-inversion control for both twisted pairs;
- a transmit/receive pair-swap control;
- a 4B/5B coding-bypass control, which is only given while the interface runs in MII mode;
- four independent link-drop mode enables;
- a port-mirror flag, which is raised only when polarity inversion and pair swap are both latched.

Top module: `strap_cfg_latch`

## Requirements
- R1: While `rst_n` is low, and after it is released, the staged and latched values are zero. Every output is 0 and every read returns 0.
- R2: A write to address 0x0B stores `reg_wdata[6:0]`, and reading 0x0B returns the stored value with bits 15:7 always 0. The bit layout is: bit 6 polarity inversion, bit 5 pair swap, bit 4 coding bypass, bits 3:0 link-drop modes.
- R3: A write to 0x0B leaves all outputs unchanged until a commit pulse latches it.
- R4: A write to 0x09 with bit 15 set raises the commit pulse for exactly the following cycle. During that cycle, reading 0x09 returns bit 15 = 1; at all other times it reads 0x0000. A write to 0x09 with bit 15 clear raises no pulse.
- R5: At the clock edge that ends the pulse cycle, the shadow registers take the staged value that was present during the pulse cycle. Every output follows from that edge on.
- R6: A write to 0x0B that lands on the edge ending a pulse cycle is staged but not latched by that pulse. A later commit latches it.
- R7: `mirror_en` is 1 exactly when the latched polarity bit and the latched pair-swap bit are both 1.
- R8: `coding_bypass` is the latched bypass bit ANDed with the live `mii_mode` input.
- R9: `link_drop_en[3:0]` equals latched bits 3:0, and `pol_invert` and `pair_swap` equal latched bits 6 and 5.
- R10: Writes to any address other than 0x0B and 0x09 change no staged value, latched value or output. Reads of such addresses return 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low hardware reset |
| reg_wr | input | 1 | Write strobe for the register port |
| reg_addr | input | 5 | Register address |
| reg_wdata | input | 16 | Write data |
| reg_rdata | output | 16 | Read data for `reg_addr` (combinational) |
| mii_mode | input | 1 | High while the MAC interface runs in MII mode |
| pol_invert | output | 1 | Latched polarity inversion |
| pair_swap | output | 1 | Latched transmit/receive pair swap |
| coding_bypass | output | 1 | Latched 4B/5B bypass, gated by MII mode |
| link_drop_en | output | 4 | Latched link-drop mode enables |
| mirror_en | output | 1 | Port-mirror flag |

## Verification
Two events can coincide at the same clock edge: the commit pulse copying the staged options into the shadows, and a new host write replacing those staged options. The bench provokes this both ways:
- a directed sequence that writes the option register in the cycle right after a completion write;
- random traffic that often issues back-to-back completion and option writes.

A cycle-accurate bench model judges each case by latching the pre-write staged value. The late write must show up only in the read-back data and must reach the outputs only at the next commit.

// File: rtl/strap_cfg_pkg.sv
package strap_cfg_pkg;

  typedef struct packed {
    logic       pol;
    logic       pswap;
    logic       bypass;
    logic [3:0] drop;
  } strap_opts_t;

  localparam int OPT_W = $bits(strap_opts_t);

  function automatic strap_opts_t opts_from_word(input logic [15:0] w);
    return strap_opts_t'(w[OPT_W-1:0]);
  endfunction

  function automatic logic [15:0] word_from_opts(input strap_opts_t o);
    return {{(16-OPT_W){1'b0}}, o};
  endfunction

  function automatic logic mirror_of(input strap_opts_t o);
    return o.pol & o.pswap;
  endfunction

endpackage

// File: rtl/strap_stage.sv
module strap_stage
  import strap_cfg_pkg::*;
#(
  parameter int ADDR_W = 5,
  parameter int DATA_W = 16,
  parameter logic [ADDR_W-1:0] OPT_ADDR = 5'h0B,
  parameter logic [ADDR_W-1:0] CTRL_ADDR = 5'h09,
  parameter int DONE_BIT = 15
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              wr_en,
  input  logic [ADDR_W-1:0] addr,
  input  logic [DATA_W-1:0] wdata,
  input  logic              pulse,
  output strap_opts_t       staged,
  output logic              commit_req,
  output logic [DATA_W-1:0] rdata
);

  logic opt_wr;

  assign opt_wr     = wr_en && (addr == OPT_ADDR);
  assign commit_req = wr_en && (addr == CTRL_ADDR) && wdata[DONE_BIT];

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) staged <= '0;
    else if (opt_wr) staged <= opts_from_word(wdata[15:0]);
  end

  always_comb begin
    rdata = '0;
    if (addr == OPT_ADDR) rdata[15:0] = word_from_opts(staged);
    else if (addr == CTRL_ADDR) rdata[DONE_BIT] = pulse;
  end

  assert_rsvd_zero_R2: assert property (@(posedge clk) disable iff (!rst_n)
    (addr == OPT_ADDR) |-> (rdata[15:OPT_W] == '0));

  assert_stage_write_R2: assert property (@(posedge clk) disable iff (!rst_n)
    opt_wr |=> (staged == $past(wdata[OPT_W-1:0])));

endmodule

// File: rtl/strap_commit.sv
module strap_commit
  import strap_cfg_pkg::*;
(
  input  logic        clk,
  input  logic        rst_n,
  input  logic        commit_req,
  input  strap_opts_t staged,
  output logic        pulse,
  output strap_opts_t shadow
);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      pulse  <= 1'b0;
      shadow <= '0;
    end else begin
      pulse <= commit_req;
      if (pulse) shadow <= staged;
    end
  end

  assert_pulse_cause_R4: assert property (@(posedge clk) disable iff (!rst_n)
    pulse |-> $past(commit_req));

  assert_pulse_single_R4: assert property (@(posedge clk) disable iff (!rst_n)
    (pulse && !commit_req) |=> !pulse);

  assert_shadow_hold_R3: assert property (@(posedge clk) disable iff (!rst_n)
    !pulse |=> $stable(shadow));

  assert_shadow_take_R5: assert property (@(posedge clk) disable iff (!rst_n)
    pulse |=> (shadow == $past(staged)));

endmodule

// File: rtl/strap_decode.sv
module strap_decode
  import strap_cfg_pkg::*;
(
  input  logic        clk,
  input  logic        rst_n,
  input  strap_opts_t shadow,
  input  logic        mii_mode,
  output logic        pol_invert,
  output logic        pair_swap,
  output logic        coding_bypass,
  output logic [3:0]  link_drop_en,
  output logic        mirror_en
);

  assign pol_invert    = shadow.pol;
  assign pair_swap     = shadow.pswap;
  assign coding_bypass = shadow.bypass & mii_mode;
  assign link_drop_en  = shadow.drop;
  assign mirror_en     = mirror_of(shadow);

  assert_mirror_R7: assert property (@(posedge clk) disable iff (!rst_n)
    mirror_en |-> (pol_invert && pair_swap));

  assert_bypass_mii_R8: assert property (@(posedge clk) disable iff (!rst_n)
    coding_bypass |-> mii_mode);

endmodule

// File: rtl/strap_cfg_latch.sv
module strap_cfg_latch
  import strap_cfg_pkg::*;
#(
  parameter int ADDR_W = 5,
  parameter int DATA_W = 16,
  parameter logic [ADDR_W-1:0] OPT_ADDR = 5'h0B,
  parameter logic [ADDR_W-1:0] CTRL_ADDR = 5'h09,
  parameter int DONE_BIT = 15
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              reg_wr,
  input  logic [ADDR_W-1:0] reg_addr,
  input  logic [DATA_W-1:0] reg_wdata,
  output logic [DATA_W-1:0] reg_rdata,
  input  logic              mii_mode,
  output logic              pol_invert,
  output logic              pair_swap,
  output logic              coding_bypass,
  output logic [3:0]        link_drop_en,
  output logic              mirror_en
);

  strap_opts_t staged;
  strap_opts_t shadow;
  logic        commit_req;
  logic        commit_pulse;

  strap_stage #(
    .ADDR_W(ADDR_W), .DATA_W(DATA_W), .OPT_ADDR(OPT_ADDR),
    .CTRL_ADDR(CTRL_ADDR), .DONE_BIT(DONE_BIT)
  ) u_stage (
    .clk(clk), .rst_n(rst_n), .wr_en(reg_wr), .addr(reg_addr),
    .wdata(reg_wdata), .pulse(commit_pulse), .staged(staged),
    .commit_req(commit_req), .rdata(reg_rdata)
  );

  strap_commit u_commit (
    .clk(clk), .rst_n(rst_n), .commit_req(commit_req), .staged(staged),
    .pulse(commit_pulse), .shadow(shadow)
  );

  strap_decode u_decode (
    .clk(clk), .rst_n(rst_n), .shadow(shadow), .mii_mode(mii_mode),
    .pol_invert(pol_invert), .pair_swap(pair_swap),
    .coding_bypass(coding_bypass), .link_drop_en(link_drop_en),
    .mirror_en(mirror_en)
  );

  assert_other_addr_R10: assert property (@(posedge clk) disable iff (!rst_n)
    (reg_wr && reg_addr != OPT_ADDR) |=> (staged == $past(staged)));

endmodule

// File: tb/tb_strap_cfg_latch.sv
`timescale 1ns/1ps
module tb_strap_cfg_latch;

  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        reg_wr = 1'b0;
  logic [4:0]  reg_addr = '0;
  logic [15:0] reg_wdata = '0;
  logic [15:0] reg_rdata;
  logic        mii_mode = 1'b1;
  logic        pol_invert, pair_swap, coding_bypass, mirror_en;
  logic [3:0]  link_drop_en;

  int errors = 0;
  int checks = 0;

  // bench model
  logic [6:0] m_stage = '0;
  logic [6:0] m_lat = '0;
  logic       m_pulse = 1'b0;

  always #4 clk = ~clk;

  strap_cfg_latch dut (
    .clk(clk), .rst_n(rst_n), .reg_wr(reg_wr), .reg_addr(reg_addr),
    .reg_wdata(reg_wdata), .reg_rdata(reg_rdata), .mii_mode(mii_mode),
    .pol_invert(pol_invert), .pair_swap(pair_swap),
    .coding_bypass(coding_bypass), .link_drop_en(link_drop_en),
    .mirror_en(mirror_en)
  );

  function automatic logic [15:0] exp_read(input logic [4:0] a);
    if (a == 5'h0B) return {9'd0, m_stage};
    if (a == 5'h09) return {m_pulse, 15'd0};
    return 16'h0000;
  endfunction

  function automatic logic [7:0] exp_outs(input logic [6:0] lat, input logic mii);
    // {pol, swap, bypass, drop[3:0], mirror}
    return {lat[6], lat[5], lat[4] & mii, lat[3:0], lat[6] & lat[5]};
  endfunction

  task automatic chk(input string tag, input logic [15:0] act, input logic [15:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s actual=%h expected=%h t=%0t", tag, act, exp, $time);
    end
  endtask

  task automatic check_all(input string tag);
    chk({tag, " outputs R9 R7 R8"},
        {8'd0, pol_invert, pair_swap, coding_bypass, link_drop_en, mirror_en},
        {8'd0, exp_outs(m_lat, mii_mode)});
    chk({tag, " readback R2 R4 R10"}, reg_rdata, exp_read(reg_addr));
  endtask

  // Drive at negedge, advance one edge, update the model, check at the next negedge.
  task automatic step(input logic w, input logic [4:0] a, input logic [15:0] d,
                      input string tag);
    logic [6:0] nlat;
    reg_wr = w; reg_addr = a; reg_wdata = d;
    @(posedge clk);
    #1;
    nlat = m_pulse ? m_stage : m_lat;
    m_pulse = w && (a == 5'h09) && d[15];
    if (w && a == 5'h0B) m_stage = d[6:0];
    m_lat = nlat;
    @(negedge clk);
    check_all(tag);
  endtask

  initial begin : watchdog
    repeat (100000) @(posedge clk);
    errors++;
    checks++;
    $display("FAIL watchdog expired");
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end

  initial begin : stim
    void'($urandom(32'h0BAD5EED));
    repeat (3) @(negedge clk);
    reg_addr = 5'h0B;
    #1 check_all("R1 in reset");
    reg_addr = 5'h09;
    #1 check_all("R1 in reset ctrl");
    @(negedge clk);
    rst_n = 1'b1;
    step(1'b0, 5'h0B, 16'h0, "R1 after reset");

    // R2: reserved bits dropped; R3: outputs held while staging
    step(1'b1, 5'h0B, 16'hFFFF, "R2 R3 full write");
    step(1'b0, 5'h0B, 16'h0, "R3 held");
    // R4 with done bit clear: no pulse
    step(1'b1, 5'h09, 16'h7FFF, "R4 no done");
    step(1'b0, 5'h09, 16'h0, "R4 no pulse");
    // R4/R5 commit
    step(1'b1, 5'h09, 16'h8000, "R4 commit write");
    step(1'b0, 5'h09, 16'h0, "R5 latched");
    step(1'b0, 5'h09, 16'h0, "R4 done cleared");
    // R8: mii gating
    mii_mode = 1'b0;
    step(1'b0, 5'h0B, 16'h0, "R8 mii low");
    mii_mode = 1'b1;
    // R6: staging write lands on the pulse-ending edge
    step(1'b1, 5'h0B, 16'h0025, "R6 stage a");
    step(1'b1, 5'h09, 16'h8000, "R6 commit");
    step(1'b1, 5'h0B, 16'h0058, "R6 late write");
    step(1'b0, 5'h0B, 16'h0, "R6 old latched");
    step(1'b1, 5'h09, 16'h8000, "R6 recommit");
    step(1'b0, 5'h0B, 16'h0, "R6 new latched");
    // R7 mirror combos
    step(1'b1, 5'h0B, 16'h0040, "R7 pol only");
    step(1'b1, 5'h09, 16'h8000, "R7 commit");
    step(1'b0, 5'h0B, 16'h0, "R7 no mirror");
    step(1'b1, 5'h0B, 16'h0060, "R7 both");
    step(1'b1, 5'h09, 16'h8000, "R7 commit2");
    step(1'b0, 5'h0B, 16'h0, "R7 mirror on");
    // R10 other addresses
    step(1'b1, 5'h0A, 16'hFFFF, "R10 wr 0A");
    step(1'b1, 5'h1F, 16'hFFFF, "R10 wr 1F");
    step(1'b0, 5'h0B, 16'h0, "R10 unchanged");

    // random traffic
    for (int i = 0; i < 3000; i++) begin
      logic [4:0]  a;
      logic [15:0] d;
      int sel;
      sel = $urandom_range(0, 9);
      if (sel < 4) a = 5'h0B;
      else if (sel < 7) a = 5'h09;
      else a = 5'($urandom_range(0, 31));
      d = 16'($urandom);
      if ($urandom_range(0, 7) == 0) mii_mode = ~mii_mode;
      step(1'($urandom_range(0, 1)), a, d, "random");
    end

    // R1 reset mid-run clears everything
    rst_n = 1'b0;
    m_stage = '0; m_lat = '0; m_pulse = 1'b0;
    reg_wr = 1'b0; reg_addr = 5'h0B;
    #2 check_all("R1 re-reset");
    @(negedge clk);
    rst_n = 1'b1;
    step(1'b0, 5'h09, 16'h0, "R1 post re-reset");

    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end

endmodule